// File: doc/BRIEF.md
# Far End Fault Pattern Codec

This block sits on the serial code-bit path of a fast Ethernet physical layer running in fiber mode. It handles the in-band far end fault signal, whose unit is a run of exactly 84 one bits closed by a single zero bit (85 bits in all). On the receive side it watches the incoming bit stream. After three such patterns arrive back to back, it raises a latched remote fault status bit. Management logic presents that bit as bit 4 of status register 1 and clears it with a read strobe.

On the transmit side, a link-OK flag comes from the local link detector. While that flag is low, the block replaces the normal transmit bits with an endless train of whole fault patterns, which tells the far end that its transmit path is broken. Once the link comes up, the current pattern is completed and normal data flows again. Outside fiber mode the whole block is inert: the status stays clear and transmit bits pass straight through. Scrambling, line coding and link detection are handled elsewhere.

Top module: `fefi_codec`

## Requirements
- R1: A received run counts as one fault pattern only when exactly 84 valid one bits are followed by a valid zero bit; a zero after fewer or more ones is a non-pattern.
- R2: The status bit `remote_fault` rises only after three consecutive patterns; any non-pattern between them restarts the count from zero.
- R3: `remote_fault` stays high once set. A read strobe (`rd_strobe` = 1) clears it only when the pattern count has fallen below three, and a read in the cycle where it would be set leaves it high.
- R4: With `fiber_en` = 0, `remote_fault` is forced to 0, both counters are cleared, and `tx_bit_out` equals `tx_bit_in` delayed by one clock.
- R5: In fiber mode with `link_ok` = 0, `tx_bit_out` carries repeating 85-bit patterns (84 ones, then a zero). The first one bit appears one clock after the first cycle with the link down.
- R6: When `link_ok` rises during a pattern, the pattern is completed before normal bits resume, with the same one-clock latency as in R4.
- R7: Receive bits are consumed only in cycles with `rx_valid` = 1; cycles with `rx_valid` = 0 neither extend nor break a run.
- R8: A synchronous active-high `rst` clears every counter, `remote_fault` and `tx_bit_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fiber_en | input | 1 | Fiber mode enable; gates detection and generation |
| rx_bit | input | 1 | Received code bit |
| rx_valid | input | 1 | rx_bit holds a new bit this cycle |
| link_ok | input | 1 | Local receiver reports a valid link |
| tx_bit_in | input | 1 | Normal transmit bit, one per clock |
| rd_strobe | input | 1 | Management read of the status bit (read-clear) |
| tx_bit_out | output | 1 | Registered transmit bit stream |
| remote_fault | output | 1 | Latched remote fault status |

## Verification
Two events can land on the same clock edge: the read-clear strobe and the setting of the status bit by the third pattern. To provoke this, the bench holds `rd_strobe` high from the closing zero of the third pattern through the edges that follow, and it requires the bit to read 1 afterwards. It then checks that the same strobe clears the bit once a non-pattern has dropped the count. On the transmit side, the rise of `link_ok` is swept across pattern offsets, including the closing zero and the first bit of the next pattern, so the end-of-pattern decision and the link change meet on one edge.

// File: rtl/fefi_pkg.sv
package fefi_pkg;
  // Transmit path operating mode
  typedef enum logic {
    TX_PASS  = 1'b0,
    TX_FAULT = 1'b1
  } tx_mode_e;

  // Receive-side classification of a finished run
  typedef struct packed {
    logic hit;   // exact-length run closed by a zero
    logic miss;  // any other zero
  } run_event_t;
endpackage

// File: rtl/fefi_rx_detect.sv
module fefi_rx_detect
  import fefi_pkg::*;
#(
  parameter int ONES_LEN = 84
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fiber_en,
  input  logic       rx_bit,
  input  logic       rx_valid,
  output run_event_t ev
);
  localparam int RW = $clog2(ONES_LEN + 2);
  localparam logic [RW-1:0] EXACT = RW'(ONES_LEN);
  localparam logic [RW-1:0] SAT   = RW'(ONES_LEN + 1);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !fiber_en) begin
      run_len <= '0;
      ev      <= '0;
    end else begin
      ev <= '0;
      if (rx_valid) begin
        if (rx_bit) begin
          if (run_len != SAT) run_len <= run_len + 1'b1;
        end else begin
          run_len <= '0;
          if (run_len == EXACT) ev.hit  <= 1'b1;
          else                  ev.miss <= 1'b1;
        end
      end
    end
  end

  assert_idle_no_event_R7: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> (ev == '0));

  assert_one_bit_no_event_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_bit) |=> (ev == '0));

  assert_saturated_run_misses_R1: assert property (@(posedge clk) disable iff (rst)
    (fiber_en && rx_valid && !rx_bit && run_len == SAT) |=> (ev.miss && !ev.hit));
endmodule

// File: rtl/fefi_status.sv
module fefi_status
  import fefi_pkg::*;
#(
  parameter int DETECT_COUNT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fiber_en,
  input  run_event_t ev,
  input  logic       rd_strobe,
  output logic       remote_fault
);
  localparam int CW = $clog2(DETECT_COUNT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DETECT_COUNT);

  logic [CW-1:0] seen;
  logic          at_limit;

  assign at_limit = (seen == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !fiber_en) begin
      seen <= '0;
    end else if (ev.miss) begin
      seen <= '0;
    end else if (ev.hit && !at_limit) begin
      seen <= seen + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !fiber_en)  remote_fault <= 1'b0;
    else if (at_limit)     remote_fault <= 1'b1;
    else if (rd_strobe)    remote_fault <= 1'b0;
  end

  assert_off_clears_R4: assert property (@(posedge clk) disable iff (rst)
    !fiber_en |=> !remote_fault);

  assert_miss_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    (fiber_en && ev.miss) |=> (seen == '0));

  assert_sticky_while_active_R3: assert property (@(posedge clk) disable iff (rst)
    (fiber_en && remote_fault && at_limit) |=> remote_fault);

  assert_latched_without_read_R3: assert property (@(posedge clk) disable iff (rst)
    (fiber_en && remote_fault && !rd_strobe) |=> remote_fault);
endmodule

// File: rtl/fefi_tx_gen.sv
module fefi_tx_gen
  import fefi_pkg::*;
#(
  parameter int ONES_LEN = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic link_ok,
  input  logic tx_bit_in,
  output logic tx_bit_out
);
  localparam int PW = $clog2(ONES_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(ONES_LEN);

  tx_mode_e      mode;
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= TX_PASS;
      pos        <= '0;
      tx_bit_out <= 1'b0;
    end else if (!fiber_en) begin
      mode       <= TX_PASS;
      pos        <= '0;
      tx_bit_out <= tx_bit_in;
    end else if (mode == TX_FAULT) begin
      tx_bit_out <= (pos != LAST);
      if (pos == LAST) begin
        pos  <= '0;
        mode <= link_ok ? TX_PASS : TX_FAULT;
      end else begin
        pos <= pos + 1'b1;
      end
    end else if (!link_ok) begin
      mode       <= TX_FAULT;
      pos        <= PW'(1);
      tx_bit_out <= 1'b1;
    end else begin
      tx_bit_out <= tx_bit_in;
    end
  end

  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (fiber_en && mode == TX_FAULT && pos == LAST) |=> !tx_bit_out);

  assert_finish_pattern_R6: assert property (@(posedge clk) disable iff (rst)
    (fiber_en && mode == TX_FAULT && pos != LAST) |=> (mode == TX_FAULT && tx_bit_out));

  assert_passthrough_off_R4: assert property (@(posedge clk) disable iff (rst)
    !fiber_en |=> (tx_bit_out == $past(tx_bit_in)));
endmodule

// File: rtl/fefi_codec.sv
module fefi_codec
  import fefi_pkg::*;
#(
  parameter int ONES_LEN     = 84,
  parameter int DETECT_COUNT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic rx_bit,
  input  logic rx_valid,
  input  logic link_ok,
  input  logic tx_bit_in,
  input  logic rd_strobe,
  output logic tx_bit_out,
  output logic remote_fault
);
  run_event_t rx_ev;

  fefi_rx_detect #(.ONES_LEN(ONES_LEN)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .fiber_en (fiber_en),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid),
    .ev       (rx_ev)
  );

  fefi_status #(.DETECT_COUNT(DETECT_COUNT)) u_stat (
    .clk          (clk),
    .rst          (rst),
    .fiber_en     (fiber_en),
    .ev           (rx_ev),
    .rd_strobe    (rd_strobe),
    .remote_fault (remote_fault)
  );

  fefi_tx_gen #(.ONES_LEN(ONES_LEN)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .fiber_en   (fiber_en),
    .link_ok    (link_ok),
    .tx_bit_in  (tx_bit_in),
    .tx_bit_out (tx_bit_out)
  );

  assert_event_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(rx_ev.hit && rx_ev.miss));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!remote_fault && !tx_bit_out));
endmodule

// File: tb/test_fefi_codec.sv
module test_fefi_codec;
  localparam int CLK_PERIOD = 10;
  localparam int N1   = 84;
  localparam int PLEN = N1 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fiber_en = 1'b1;
  logic rx_bit = 1'b0;
  logic rx_valid = 1'b0;
  logic link_ok = 1'b1;
  logic tx_bit_in = 1'b0;
  logic rd_strobe = 1'b0;
  logic tx_bit_out;
  logic remote_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fefi_codec #(.ONES_LEN(N1), .DETECT_COUNT(3)) i_fefi_codec (
    .clk(clk), .rst(rst), .fiber_en(fiber_en), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .link_ok(link_ok), .tx_bit_in(tx_bit_in),
    .rd_strobe(rd_strobe), .tx_bit_out(tx_bit_out), .remote_fault(remote_fault)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // n valid ones, optional invalid zero cycles mixed in, then one valid zero
  task automatic send_run(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 9 == 4)) begin
        rx_valid = 1'b0; rx_bit = 1'b0; tick();
      end
      rx_valid = 1'b1; rx_bit = 1'b1; tick();
    end
    rx_valid = 1'b1; rx_bit = 1'b0; tick();
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_status();
    send_run(0, 1'b0);
    idle(4);
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
    idle(1);
  endtask

  // Transmit sweep: link low for 'low_len' cycles, optional fiber drop cycle
  task automatic tx_run(input int low_len, input int drop_at);
    bit ma;
    int mp;
    logic e;
    string tag;
    ma = 1'b0; mp = 0;
    link_ok = 1'b1; fiber_en = 1'b1;
    idle(PLEN + 2);
    for (int t = 0; t < low_len + 2 * PLEN + 10; t++) begin
      link_ok   = !(t >= 5 && t < 5 + low_len);
      fiber_en  = (t != drop_at);
      tx_bit_in = ((t * 5 + 3) % 7) < 3;
      if (!fiber_en) begin
        ma = 1'b0; mp = 0; e = tx_bit_in; tag = "R4";
      end else if (ma) begin
        e   = (mp != N1);
        tag = link_ok ? "R6" : "R5";
        if (mp == N1) begin mp = 0; ma = !link_ok; end
        else mp++;
      end else if (!link_ok) begin
        ma = 1'b1; mp = 1; e = 1'b1; tag = "R5";
      end else begin
        e = tx_bit_in; tag = "R6";
      end
      tick();
      chk(tx_bit_out, e, tag);
    end
    link_ok = 1'b1; fiber_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(3);
    chk(remote_fault, 1'b0, "R8 status");
    chk(tx_bit_out, 1'b0, "R8 tx");
    rst = 1'b0;

    // R2: two patterns are not enough, the third sets the bit
    send_run(N1, 1'b0); send_run(N1, 1'b0); idle(5);
    chk(remote_fault, 1'b0, "R2 two patterns");
    send_run(N1, 1'b0); idle(5);
    chk(remote_fault, 1'b1, "R2 three patterns");

    // R3: read while still detected keeps it; latched after a miss
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0; idle(1);
    chk(remote_fault, 1'b1, "R3 read while active");
    send_run(3, 1'b0); idle(5);
    chk(remote_fault, 1'b1, "R3 latched after miss");
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0; idle(1);
    chk(remote_fault, 1'b0, "R3 read clears");

    // R1/R2: sweep middle run length around the exact value
    for (int n = N1 - 6; n <= N1 + 6; n++) begin
      clear_status();
      send_run(N1, 1'b0); send_run(n, 1'b0); send_run(N1, 1'b0); idle(5);
      chk(remote_fault, (n == N1), (n == N1) ? "R1 exact run" : "R2 broken chain");
    end

    // R7: invalid zero cycles inside runs do not break them
    clear_status();
    send_run(N1, 1'b1); send_run(N1, 1'b1); send_run(N1, 1'b1); idle(5);
    chk(remote_fault, 1'b1, "R7 gaps ignored");

    // R3: read held across the setting edge
    clear_status();
    send_run(N1, 1'b0); send_run(N1, 1'b0); send_run(N1, 1'b0);
    rd_strobe = 1'b1; idle(5); rd_strobe = 1'b0; idle(1);
    chk(remote_fault, 1'b1, "R3 set beats read");
    send_run(0, 1'b0); idle(4);
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0; idle(1);
    chk(remote_fault, 1'b0, "R3 clear after miss");

    // R4: fiber mode off clears status and counters
    send_run(N1, 1'b0); send_run(N1, 1'b0); send_run(N1, 1'b0); idle(5);
    fiber_en = 1'b0; tick(); fiber_en = 1'b1; idle(1);
    chk(remote_fault, 1'b0, "R4 status cleared");
    send_run(N1, 1'b0); idle(5);
    chk(remote_fault, 1'b0, "R4 count cleared");
    fiber_en = 1'b0;
    send_run(N1, 1'b0); send_run(N1, 1'b0); send_run(N1, 1'b0); idle(5);
    chk(remote_fault, 1'b0, "R4 no detection off");
    fiber_en = 1'b1;

    // R5/R6/R4: transmit sweep of link-up offsets
    tx_run(0, -1);
    tx_run(1, -1);
    tx_run(40, -1);
    tx_run(N1, -1);
    tx_run(PLEN, -1);
    tx_run(PLEN + 1, -1);
    tx_run(2 * PLEN - 1, -1);
    tx_run(2 * PLEN + 7, -1);
    tx_run(3 * PLEN, 60);

    // R4: passthrough with link down and fiber mode off
    fiber_en = 1'b0; link_ok = 1'b0;
    for (int t = 0; t < 20; t++) begin
      tx_bit_in = t[0] ^ t[2];
      tick();
      chk(tx_bit_out, t[0] ^ t[2], "R4 passthrough");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule